// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This block sits between a general-purpose timer and a bank of edge-triggered external interrupt channels. The timer reports four one-cycle event strobes: output compare, a capture on pin A, a capture on pin B, and counter overflow. Each strobe sets a sticky status flag. Software clears the flags with a write-one-to-clear access. Per-source enable bits gate the flags into three requests: compare, capture and overflow. A single capture enable covers both capture pins.

A global mode bit chooses how the requests are routed. In split mode, compare, capture and overflow drive three adjacent channels, starting at `TMR_BASE`, and each has its own select bit. In shared mode, the three requests are ORed onto channel `TMR_BASE`. The two channels above it then return to their external lines. Because the shared channel reacts only to a transition of the combined level, it re-arms only after every enabled flag has gone back to zero together.

Every channel registers its routed line and compares it with the previous value. On the chosen edge it sets a pending bit. Software can clear that bit before opening the mask, so a stale request does not fire. A channel requests an interrupt when its pending bit and its mask bit are both 1, and it presents its priority level with the request.

Top module: `tmr_irq_route`

## Requirements
- R1: After reset, `status`, `pending`, `irq` and `irq_prio` are all zero.
- R2: A strobe on `evt_cmp`, `evt_cap_a`, `evt_cap_b` or `evt_ovf` sets `status` bit 0, 1, 2 or 3 respectively, one clock later. The bit holds until it is cleared.
- R3: With `st_clr_we`=1, every `status` bit whose `st_clr` bit is 1 is cleared. When a set and a clear of the same bit land in the same cycle, the set wins.
- R4: With `shared_mode`=0, routing is as follows:
  - Channel `TMR_BASE` carries `status[0]&src_en[0]&src_sel[0]`.
  - Channel `TMR_BASE+1` carries `(status[1]|status[2])&src_en[1]&src_sel[1]`. The one capture enable therefore covers both capture pins.
  - Channel `TMR_BASE+2` carries `status[3]&src_en[2]&src_sel[2]`.
  - `ext_line` is ignored on these three channels.
- R5: With `shared_mode`=1, channel `TMR_BASE` carries `(status[0]&src_en[0])|((status[1]|status[2])&src_en[1])|(status[3]&src_en[2])`. In this mode:
  - `src_sel` and `ext_line[TMR_BASE]` are ignored.
  - Channels `TMR_BASE+1` and `TMR_BASE+2` follow their `ext_line` bits.
- R6: Channels outside the timer window always follow their `ext_line` bit.
- R7: A channel sets its `pending` bit one clock after its routed line changes, as follows:
  - With `ch_rise`=1, it reacts to a 0-to-1 change.
  - With `ch_rise`=0, it reacts to a 1-to-0 change.
  - A line held at a constant level sets nothing. A shared channel therefore raises nothing new until all of its enabled flags are clear at once.
- R8: With `pend_clr_we`=1, every `pending` bit whose `pend_clr` bit is 1 is cleared. A simultaneous edge wins.
- R9: `irq[i]` is `pending[i]&ch_mask[i]`. `irq_prio[i*PRIO_W +: PRIO_W]` equals `ch_prio` for that channel while `irq[i]` is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_cmp | input | 1 | Output-compare event strobe |
| evt_cap_a | input | 1 | Capture pin A event strobe |
| evt_cap_b | input | 1 | Capture pin B event strobe |
| evt_ovf | input | 1 | Overflow event strobe |
| st_clr_we | input | 1 | Status clear write strobe |
| st_clr | input | 4 | Status bits to clear |
| src_en | input | 3 | Enables: compare, capture, overflow |
| src_sel | input | 3 | Split-mode selects: compare, capture, overflow |
| shared_mode | input | 1 | 1 = all timer requests on one channel |
| ext_line | input | N_CH | External request lines |
| ch_rise | input | N_CH | Per-channel edge: 1 rising, 0 falling |
| ch_mask | input | N_CH | Per-channel mask (1 = enabled) |
| ch_prio | input | N_CH*PRIO_W | Per-channel priority levels |
| pend_clr_we | input | 1 | Pending clear write strobe |
| pend_clr | input | N_CH | Pending bits to clear |
| status | output | 4 | Timer status flags |
| pending | output | N_CH | Channel pending bits |
| irq | output | N_CH | Channel interrupt requests |
| irq_prio | output | N_CH*PRIO_W | Priority presented with each request |

## Verification
The assertions assume the following about the inputs:
- Event strobes and clear writes are sampled as synchronous levels.
- `TMR_BASE+2` lies inside the channel range.
- A pending bit can only rise after its routed line differed from the registered copy.

The stimulus drives every input on the falling clock edge. Before each measured event it clears all flags and waits until the registered lines have settled to zero. It then clears pending, so that each expected pending vector follows from a single edge. The sweeps cover every enable and select combination against every event source, in both routing modes.

// File: rtl/tmr_irq_pkg.sv
// Shared indices for the timer interrupt routing unit.
// Assumes: four status flags, three routed request types.
package tmr_irq_pkg;
    localparam int N_FLAGS   = 4;
    localparam int FLG_CMP   = 0;
    localparam int FLG_CAP_A = 1;
    localparam int FLG_CAP_B = 2;
    localparam int FLG_OVF   = 3;
    localparam int N_REQ     = 3;
    localparam int REQ_CMP   = 0;
    localparam int REQ_CAP   = 1;
    localparam int REQ_OVF   = 2;
endpackage

// File: rtl/tmr_status_flags.sv
// Sticky timer status flags: set by one-cycle strobes, cleared by a
// write-one-to-clear access. Assumes strobes are synchronous to clk.
// A set and a clear of the same flag in one cycle leaves the flag set.
module tmr_status_flags
    import tmr_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] evt,
    input  logic               clr_we,
    input  logic [N_FLAGS-1:0] clr,
    output logic [N_FLAGS-1:0] flags
);
    logic [N_FLAGS-1:0] clr_eff;

    // Qualify the clear mask with its write strobe.
    always_comb clr_eff = clr_we ? clr : '0;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_eff) | evt;
    end
endmodule

// File: rtl/tmr_src_router.sv
// Combines gated timer flags into requests and places them on the
// channel lines. Split mode uses three channels from BASE, each with
// its own select. Shared mode ORs all three requests onto BASE.
// Assumes BASE+2 < N_CH.
module tmr_src_router
    import tmr_irq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int BASE = 2
) (
    input  logic [N_FLAGS-1:0] flags,
    input  logic [N_REQ-1:0]   src_en,
    input  logic [N_REQ-1:0]   src_sel,
    input  logic               shared_mode,
    input  logic [N_CH-1:0]    ext_line,
    output logic [N_CH-1:0]    route_line
);
    logic [N_REQ-1:0] req;

    // Gate each flag group with its enable; one enable covers both capture pins.
    always_comb begin
        req[REQ_CMP] = flags[FLG_CMP] & src_en[REQ_CMP];
        req[REQ_CAP] = (flags[FLG_CAP_A] | flags[FLG_CAP_B]) & src_en[REQ_CAP];
        req[REQ_OVF] = flags[FLG_OVF] & src_en[REQ_OVF];
    end

    // Place requests on channels; all other channels pass ext_line through.
    always_comb begin
        route_line = ext_line;
        if (shared_mode) begin
            route_line[BASE] = |req;
        end else begin
            route_line[BASE + REQ_CMP] = req[REQ_CMP] & src_sel[REQ_CMP];
            route_line[BASE + REQ_CAP] = req[REQ_CAP] & src_sel[REQ_CAP];
            route_line[BASE + REQ_OVF] = req[REQ_OVF] & src_sel[REQ_OVF];
        end
    end
endmodule

// File: rtl/irq_edge_channel.sv
// One external interrupt channel: registers its line, detects the
// selected edge, holds a pending latch, applies the mask and presents
// the priority. Assumes the line is synchronous to clk. An edge beats
// a simultaneous software clear.
module irq_edge_channel #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              rise_sel,
    input  logic              clr,
    input  logic              mask,
    input  logic [PRIO_W-1:0] prio,
    output logic              line_q,
    output logic              edge_hit,
    output logic              pending,
    output logic              irq,
    output logic [PRIO_W-1:0] irq_prio
);
    // Previous-value register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line;
    end

    // Edge of the selected polarity between the current and previous value.
    always_comb edge_hit = rise_sel ? (line & ~line_q) : (~line & line_q);

    // Pending latch: set by edge, cleared by software, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~clr) | edge_hit;
    end

    // Masked request and its priority tag.
    always_comb begin
        irq      = pending & mask;
        irq_prio = irq ? prio : '0;
    end
endmodule

// File: rtl/tmr_irq_route.sv
// Timer interrupt routing unit top: status flags, request routing and a
// bank of N_CH edge-triggered interrupt channels. Assumes TMR_BASE+2 < N_CH.
module tmr_irq_route
    import tmr_irq_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int PRIO_W   = 3,
    parameter int TMR_BASE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     evt_cmp,
    input  logic                     evt_cap_a,
    input  logic                     evt_cap_b,
    input  logic                     evt_ovf,
    input  logic                     st_clr_we,
    input  logic [3:0]               st_clr,
    input  logic [2:0]               src_en,
    input  logic [2:0]               src_sel,
    input  logic                     shared_mode,
    input  logic [N_CH-1:0]          ext_line,
    input  logic [N_CH-1:0]          ch_rise,
    input  logic [N_CH-1:0]          ch_mask,
    input  logic [N_CH*PRIO_W-1:0]   ch_prio,
    input  logic                     pend_clr_we,
    input  logic [N_CH-1:0]          pend_clr,
    output logic [3:0]               status,
    output logic [N_CH-1:0]          pending,
    output logic [N_CH-1:0]          irq,
    output logic [N_CH*PRIO_W-1:0]   irq_prio
);
    logic [N_FLAGS-1:0] evt_vec;
    logic [N_CH-1:0]    route_line;
    logic [N_CH-1:0]    line_q;
    logic [N_CH-1:0]    edge_hit;
    logic [N_CH-1:0]    clr_vec;

    // Gather strobes in flag order and qualify the pending clear.
    always_comb begin
        evt_vec              = '0;
        evt_vec[FLG_CMP]     = evt_cmp;
        evt_vec[FLG_CAP_A]   = evt_cap_a;
        evt_vec[FLG_CAP_B]   = evt_cap_b;
        evt_vec[FLG_OVF]     = evt_ovf;
        clr_vec              = pend_clr_we ? pend_clr : '0;
    end

    tmr_status_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr_we (st_clr_we),
        .clr    (st_clr),
        .flags  (status)
    );

    tmr_src_router #(.N_CH(N_CH), .BASE(TMR_BASE)) u_router (
        .flags       (status),
        .src_en      (src_en),
        .src_sel     (src_sel),
        .shared_mode (shared_mode),
        .ext_line    (ext_line),
        .route_line  (route_line)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        irq_edge_channel #(.PRIO_W(PRIO_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .line     (route_line[i]),
            .rise_sel (ch_rise[i]),
            .clr      (clr_vec[i]),
            .mask     (ch_mask[i]),
            .prio     (ch_prio[i*PRIO_W +: PRIO_W]),
            .line_q   (line_q[i]),
            .edge_hit (edge_hit[i]),
            .pending  (pending[i]),
            .irq      (irq[i]),
            .irq_prio (irq_prio[i*PRIO_W +: PRIO_W])
        );
    end
endmodule

// File: rtl/tmr_irq_route_chk.sv
// Assertion checker for tmr_irq_route, attached by bind below.
// Assumes inputs are synchronous levels sampled at posedge clk.
module tmr_irq_route_chk #(
    parameter int N_CH     = 8,
    parameter int PRIO_W   = 3,
    parameter int TMR_BASE = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             evt_vec,
    input logic                   st_clr_we,
    input logic [3:0]             st_clr,
    input logic [3:0]             status,
    input logic [N_CH-1:0]        route_line,
    input logic [N_CH-1:0]        line_q,
    input logic [N_CH-1:0]        edge_hit,
    input logic                   pend_clr_we,
    input logic [N_CH-1:0]        pend_clr,
    input logic [N_CH-1:0]        ch_mask,
    input logic [N_CH-1:0]        pending,
    input logic [N_CH-1:0]        irq,
    input logic [N_CH*PRIO_W-1:0] irq_prio
);
    initial begin
        assert_base_fits_R4: assert (TMR_BASE + 2 < N_CH)
            else $error("timer window exceeds channel count");
    end

    for (genvar k = 0; k < 4; k++) begin : g_flag
        assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_vec[k] |=> status[k]);
        assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_clr_we && st_clr[k] && !evt_vec[k]) |=> !status[k]);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        assert_pend_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[i]) |-> $past(route_line[i] != line_q[i]));
        assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_clr_we && pend_clr[i] && !edge_hit[i]) |=> !pending[i]);
        assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_mask[i] |-> !irq[i]);
        assert_prio_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_prio[i*PRIO_W +: PRIO_W] != '0) |-> irq[i]);
    end
endmodule

bind tmr_irq_route tmr_irq_route_chk #(
    .N_CH(N_CH), .PRIO_W(PRIO_W), .TMR_BASE(TMR_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_vec     (evt_vec),
    .st_clr_we   (st_clr_we),
    .st_clr      (st_clr),
    .status      (status),
    .route_line  (route_line),
    .line_q      (line_q),
    .edge_hit    (edge_hit),
    .pend_clr_we (pend_clr_we),
    .pend_clr    (pend_clr),
    .ch_mask     (ch_mask),
    .pending     (pending),
    .irq         (irq),
    .irq_prio    (irq_prio)
);

// File: tb/tmr_irq_route_tb.sv
module tmr_irq_route_tb;
    localparam int N_CH = 8;
    localparam int PW   = 3;
    localparam int B    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_cmp = 0, evt_cap_a = 0, evt_cap_b = 0, evt_ovf = 0;
    logic st_clr_we = 0;
    logic [3:0] st_clr = '0;
    logic [2:0] src_en = '0, src_sel = '0;
    logic shared_mode = 0;
    logic [N_CH-1:0] ext_line = '0, ch_rise = '1, ch_mask = '1, pend_clr = '0;
    logic [N_CH*PW-1:0] ch_prio = '0;
    logic pend_clr_we = 0;
    logic [3:0] status;
    logic [N_CH-1:0] pending, irq;
    logic [N_CH*PW-1:0] irq_prio;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_irq_route #(.N_CH(N_CH), .PRIO_W(PW), .TMR_BASE(B)) u_dut (.*);

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N_CH*PW-1:0] exp_prio(input logic [N_CH-1:0] req_v);
        logic [N_CH*PW-1:0] r = '0;
        for (int i = 0; i < N_CH; i++)
            if (req_v[i]) r[i*PW +: PW] = PW'((i * 3 + 1) % 8);
        return r;
    endfunction

    task automatic pulse_evt(input int ev);
        evt_cmp = (ev == 0); evt_cap_a = (ev == 1);
        evt_cap_b = (ev == 2); evt_ovf = (ev == 3);
        step(1);
        evt_cmp = 0; evt_cap_a = 0; evt_cap_b = 0; evt_ovf = 0;
    endtask

    // Clear all flags, let lines settle, then clear all pending bits.
    task automatic clean();
        st_clr_we = 1; st_clr = 4'hF; step(1);
        st_clr_we = 0; st_clr = '0; step(2);
        pend_clr_we = 1; pend_clr = '1; step(1);
        pend_clr_we = 0; pend_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N_CH-1:0] ex;
        for (int i = 0; i < N_CH; i++) ch_prio[i*PW +: PW] = PW'((i * 3 + 1) % 8);
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        check("R1 status", 32'(status), 0);
        check("R1 pending", 32'(pending), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 irq_prio", 32'(irq_prio), 0);

        // R4 split-mode sweep (also R2 flag set, R9 request/priority)
        for (int en = 0; en < 8; en++)
            for (int sel = 0; sel < 8; sel++)
                for (int ev = 0; ev < 4; ev++) begin
                    src_en = 3'(en); src_sel = 3'(sel); shared_mode = 0;
                    ext_line = '0; ext_line[B+1] = 1'(ev & 1);
                    clean();
                    pulse_evt(ev);
                    step(1);
                    ex = '0;
                    if (ev == 0 && en[0] && sel[0]) ex[B] = 1;
                    if ((ev == 1 || ev == 2) && en[1] && sel[1]) ex[B+1] = 1;
                    if (ev == 3 && en[2] && sel[2]) ex[B+2] = 1;
                    check("R2 status", 32'(status), 32'(1 << ev));
                    check("R4 pending", 32'(pending), 32'(ex));
                    check("R9 irq", 32'(irq), 32'(ex));
                    check("R9 irq_prio", 32'(irq_prio), 32'(exp_prio(ex)));
                end

        // R5 shared-mode sweep; ext_line at BASE toggles without effect
        for (int en = 0; en < 8; en++)
            for (int ev = 0; ev < 4; ev++) begin
                src_en = 3'(en); src_sel = ~3'(en); shared_mode = 1;
                ext_line = '0;
                clean();
                ext_line[B] = 1;
                pulse_evt(ev);
                ext_line[B] = 0;
                step(1);
                ex = '0;
                if ((ev == 0 && en[0]) || ((ev == 1 || ev == 2) && en[1]) || (ev == 3 && en[2]))
                    ex[B] = 1;
                check("R5 pending", 32'(pending), 32'(ex));
            end

        // R5 shared-mode channels BASE+1/BASE+2 follow ext_line
        clean();
        ext_line[B+2] = 1; step(1);
        check("R5 ext on BASE+2", 32'(pending[B+2]), 1);
        ext_line = '0;

        // R7 shared channel re-arms only after all flags clear
        src_en = 3'b111; shared_mode = 1;
        clean();
        pulse_evt(0); step(1);
        check("R7 first shared edge", 32'(pending[B]), 1);
        pend_clr_we = 1; pend_clr = '0; pend_clr[B] = 1; step(1);
        pend_clr_we = 0; pend_clr = '0;
        pulse_evt(3); step(2);
        check("R7 no edge while level high", 32'(pending[B]), 0);
        st_clr_we = 1; st_clr = 4'b0001; step(1);
        st_clr_we = 0; st_clr = '0; step(2);
        check("R7 partial clear no edge", 32'(pending[B]), 0);
        check("R3 partial clear status", 32'(status), 32'h8);
        st_clr_we = 1; st_clr = 4'b1000; step(1);
        st_clr_we = 0; st_clr = '0; step(1);
        check("R3 all clear status", 32'(status), 0);
        pulse_evt(2); step(1);
        check("R7 re-armed edge", 32'(pending[B]), 1);

        // R3 set wins over clear in the same cycle
        clean();
        st_clr_we = 1; st_clr = 4'hF; evt_cmp = 1; step(1);
        st_clr_we = 0; st_clr = '0; evt_cmp = 0;
        check("R3 set wins", 32'(status), 1);

        // R6/R7 falling edge on a non-timer channel
        shared_mode = 0;
        clean();
        ch_rise[6] = 0;
        ext_line[6] = 1; step(2);
        check("R7 falling: no set on rise", 32'(pending[6]), 0);
        ext_line[6] = 0; step(1);
        check("R7 falling edge sets", 32'(pending[6]), 1);
        ch_rise[6] = 1;

        // R8 edge wins over clear; R9 mask gates irq and priority
        clean();
        ch_mask[7] = 0;
        ext_line[7] = 1; pend_clr_we = 1; pend_clr[7] = 1; step(1);
        pend_clr_we = 0; pend_clr = '0;
        check("R8 edge beats clear", 32'(pending[7]), 1);
        check("R9 masked irq", 32'(irq[7]), 0);
        check("R9 masked prio", 32'(irq_prio[7*PW +: PW]), 0);
        pend_clr_we = 1; pend_clr[7] = 1; step(1);
        pend_clr_we = 0; pend_clr = '0;
        check("R8 pending cleared", 32'(pending[7]), 0);
        ch_mask[7] = 1; step(1);
        check("R8 no stale irq after unmask", 32'(irq[7]), 0);
        ext_line[7] = 0; step(1);
        ext_line[7] = 1; step(1);
        check("R9 irq with prio", 32'(irq_prio[7*PW +: PW]), 32'((7 * 3 + 1) % 8));
        check("R6 ext channel pending", 32'(pending), 32'(8'h80));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule